// File: doc/BRIEF.md
# Gate Driver Protection Sequencer

This block supervises a three-phase gate pre-driver. Digital comparator flags come in: supply good on the main input rail, on the gate-drive rail and on each of the three bootstrap rails, current-sense above the trip level and below the release level, low-side drain-source overcurrent, output short to ground and over-temperature. A sleep request also comes in. Three controls go out: a global enable for the six gate outputs, a per-phase low-side bootstrap-refresh command and an active-low fault flag.

Once both supplies are good, the block charges the bootstrap capacitors. It turns on the low-side switch of phase A, then B, then C, each for a fixed number of clock cycles, and only after that enables the outputs. Faults recover in one of three ways. A current-limit trip clears by itself once the release flag is seen. A short or thermal event latches until a sleep cycle or an undervoltage clears it. A gate-rail or bootstrap undervoltage reruns the refresh sequence. After a sleep request is released, the block waits out a settling window before it starts the refresh. All outputs come from registers and respond on the clock edge that follows the input change.

Top module: `gd_prot_seq`

## Requirements
- R1: During reset, and one cycle after `vinOk` is low in any state, `outEnable`=0, `lsRefresh`=000 and `faultN`=1. A low `vinOk` also clears a latched fault.
- R2: From the off state, the refresh sequence starts only on a cycle where `vinOk` and `vregOk` are both 1. With either one low, all outputs stay off and `faultN` stays 1.
- R3: The refresh sequence drives `lsRefresh` to 001 (phase A), then 010 (phase B), then 100 (phase C), each for REFRESH_CYCLES cycles, with `faultN`=1. `outEnable` rises on the next cycle. Fault, current-sense and bootstrap flags have no effect during the sequence.
- R4: One cycle after `sleepReq` is 1, all outputs are off and `faultN`=1. While sleep is held, every other input except `vinOk` is ignored. After release, outputs stay off for WAKE_CYCLES cycles, and then the R3 sequence runs.
- R5: While running, `csHigh` or `vdsOc` drops `outEnable` and `faultN` to 0 one cycle later. They stay at 0 until `csLow` is seen, and on the next cycle `outEnable` and `faultN` return to 1.
- R6: `shortGnd` or `overTemp` while running or in a current fault drives `outEnable`=0 and `faultN`=0. These values hold regardless of the fault inputs and `csLow` until sleep, a gate-rail undervoltage or a main-rail undervoltage occurs.
- R7: `vregOk` low after the off state drives all outputs off with `faultN`=0. When `vregOk` returns, the R3 sequence reruns.
- R8: Any `bstOk` bit at 0 while running or in a current fault restarts the R3 sequence, beginning with phase A on the next cycle.
- R9: `lsRefresh` is one-hot or zero, and it is never active at the same time as `outEnable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vinOk | input | 1 | Main input rail above its minimum |
| vregOk | input | 1 | Gate-drive rail above its undervoltage level |
| bstOk | input | 3 | Bootstrap rails good, bit 0 = phase A |
| csHigh | input | 1 | Current-sense node above the trip level |
| csLow | input | 1 | Current-sense node below the release level |
| vdsOc | input | 1 | Low-side drain-source overcurrent |
| shortGnd | input | 1 | Output short to ground detected |
| overTemp | input | 1 | Die over-temperature |
| sleepReq | input | 1 | Sleep request, active high |
| outEnable | output | 1 | Global enable for all six gate outputs |
| lsRefresh | output | 3 | Low-side on command for bootstrap charging, bit 0 = phase A |
| faultN | output | 1 | Registered active-low fault flag |

## Verification
A wrong state shows on the three outputs one cycle after the input that caused it. A lost latch shows as `faultN` returning to 1 while `csLow` is held. A skipped phase shows as a refresh window that is shifted in time or missing. A miscounted window moves the `outEnable` rise by a whole number of cycles. The bench therefore compares all five output bits after every edge of each refresh and wake window. Faults are also applied during the refresh and sleep windows, where the outputs must stay unchanged.

// File: rtl/gd_prot_pkg.sv
package gd_prot_pkg;
  localparam int PHASES = 3;

  typedef enum logic [3:0] {
    ST_OFF, ST_REF_A, ST_REF_B, ST_REF_C, ST_WAKE,
    ST_RUN, ST_CSF, ST_LATCH, ST_VREGUV, ST_SLEEP
  } seqState_t;

  typedef struct packed {
    logic              cntClear;
    logic              useWake;
    logic              drvEnable;
    logic              drvFaultN;
    logic [PHASES-1:0] drvRefresh;
  } seqStrobe_t;
endpackage

// File: rtl/gd_prot_timer.sv
module gd_prot_timer
  import gd_prot_pkg::*;
#(
  parameter int REFRESH_CYCLES = 50000,
  parameter int WAKE_CYCLES    = 125000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strb,
  output logic              cntDone,
  output logic              outEnable,
  output logic [PHASES-1:0] lsRefresh,
  output logic              faultN
);
  localparam int MAX_CYC = (REFRESH_CYCLES > WAKE_CYCLES) ? REFRESH_CYCLES : WAKE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] REF_LAST  = CNT_W'(REFRESH_CYCLES - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign cntDone = (cnt == (strb.useWake ? WAKE_LAST : REF_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      outEnable <= 1'b0;
      lsRefresh <= '0;
      faultN    <= 1'b1;
    end else begin
      cnt       <= strb.cntClear ? '0 : cnt + 1'b1;
      outEnable <= strb.drvEnable;
      lsRefresh <= strb.drvRefresh;
      faultN    <= strb.drvFaultN;
    end
  end

  // R9: refresh pulses never overlap each other
  a_r9_refresh_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lsRefresh));
  // R9: refresh never while outputs are enabled
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(outEnable && (lsRefresh != '0)));
endmodule

// File: rtl/gd_prot_ctrl.sv
module gd_prot_ctrl
  import gd_prot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vinOk,
  input  logic              vregOk,
  input  logic [PHASES-1:0] bstOk,
  input  logic              csHigh,
  input  logic              csLow,
  input  logic              vdsOc,
  input  logic              shortGnd,
  input  logic              overTemp,
  input  logic              sleepReq,
  input  logic              cntDone,
  output seqStrobe_t        strb
);
  seqState_t state, nextState;
  logic latchHit, bstBad, csTrip;

  assign latchHit = shortGnd | overTemp;
  assign bstBad   = ~&bstOk;
  assign csTrip   = csHigh | vdsOc;

  always_comb begin
    nextState = state;
    if (!vinOk) nextState = ST_OFF;
    else if (sleepReq) nextState = ST_SLEEP;
    else begin
      case (state)
        ST_OFF:    if (vregOk) nextState = ST_REF_A;
        ST_SLEEP:  nextState = ST_WAKE;
        ST_VREGUV: if (vregOk) nextState = ST_REF_A;
        default: begin
          if (!vregOk) nextState = ST_VREGUV;
          else begin
            case (state)
              ST_WAKE:  if (cntDone) nextState = ST_REF_A;
              ST_REF_A: if (cntDone) nextState = ST_REF_B;
              ST_REF_B: if (cntDone) nextState = ST_REF_C;
              ST_REF_C: if (cntDone) nextState = ST_RUN;
              ST_RUN: begin
                if (latchHit) nextState = ST_LATCH;
                else if (bstBad) nextState = ST_REF_A;
                else if (csTrip) nextState = ST_CSF;
              end
              ST_CSF: begin
                if (latchHit) nextState = ST_LATCH;
                else if (bstBad) nextState = ST_REF_A;
                else if (csLow) nextState = ST_RUN;
              end
              default: nextState = state;
            endcase
          end
        end
      endcase
    end
  end

  always_comb begin
    strb.cntClear   = (nextState != state);
    strb.useWake    = (state == ST_WAKE);
    strb.drvEnable  = (nextState == ST_RUN);
    strb.drvFaultN  = !(nextState inside {ST_CSF, ST_LATCH, ST_VREGUV});
    strb.drvRefresh = {nextState == ST_REF_C, nextState == ST_REF_B, nextState == ST_REF_A};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nextState;
  end

  // R1: main-rail loss returns to the off state
  a_r1_vin_off: assert property (@(posedge clk) disable iff (!rst_n)
    !vinOk |=> state == ST_OFF);
  // R4: sleep request wins over everything but main-rail loss
  a_r4_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (vinOk && sleepReq) |=> state == ST_SLEEP);
  // R5: current trip from run
  a_r5_cs_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && vinOk && !sleepReq && vregOk && !latchHit && !bstBad && csTrip)
      |=> state == ST_CSF);
  // R6: latch holds without sleep or undervoltage
  a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LATCH && vinOk && vregOk && !sleepReq) |=> state == ST_LATCH);
  // R7: gate-rail loss while running
  a_r7_vreg_uv: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && vinOk && !sleepReq && !vregOk) |=> state == ST_VREGUV);
  // R3: refresh phases advance in order
  a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REF_B) |-> $past(state) inside {ST_REF_A, ST_REF_B});
endmodule

// File: rtl/gd_prot_seq.sv
module gd_prot_seq
  import gd_prot_pkg::*;
#(
  parameter int REFRESH_CYCLES = 50000,
  parameter int WAKE_CYCLES    = 125000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vinOk,
  input  logic       vregOk,
  input  logic [2:0] bstOk,
  input  logic       csHigh,
  input  logic       csLow,
  input  logic       vdsOc,
  input  logic       shortGnd,
  input  logic       overTemp,
  input  logic       sleepReq,
  output logic       outEnable,
  output logic [2:0] lsRefresh,
  output logic       faultN
);
  seqStrobe_t strb;
  logic cntDone;

  gd_prot_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .vinOk(vinOk), .vregOk(vregOk), .bstOk(bstOk),
    .csHigh(csHigh), .csLow(csLow), .vdsOc(vdsOc), .shortGnd(shortGnd),
    .overTemp(overTemp), .sleepReq(sleepReq), .cntDone(cntDone), .strb(strb)
  );

  gd_prot_timer #(.REFRESH_CYCLES(REFRESH_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cntDone(cntDone),
    .outEnable(outEnable), .lsRefresh(lsRefresh), .faultN(faultN)
  );
endmodule

// File: tb/gd_prot_seq_tb_top.sv
module gd_prot_seq_tb_top;
  localparam int REF  = 4;
  localparam int WAKE = 6;
  localparam logic [4:0] OFFV = 5'b0_000_1;
  localparam logic [4:0] RUNV = 5'b1_000_1;
  localparam logic [4:0] FLTV = 5'b0_000_0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vinOk = 0, vregOk = 0, csHigh = 0, csLow = 1, vdsOc = 0, shortGnd = 0, overTemp = 0, sleepReq = 0;
  logic [2:0] bstOk = 3'b111;
  logic outEnable, faultN;
  logic [2:0] lsRefresh;
  int nChecks = 0, nFail = 0;

  always #4 clk = ~clk;

  gd_prot_seq #(.REFRESH_CYCLES(REF), .WAKE_CYCLES(WAKE)) dut_i (
    .clk(clk), .rst_n(rst_n), .vinOk(vinOk), .vregOk(vregOk), .bstOk(bstOk),
    .csHigh(csHigh), .csLow(csLow), .vdsOc(vdsOc), .shortGnd(shortGnd),
    .overTemp(overTemp), .sleepReq(sleepReq),
    .outEnable(outEnable), .lsRefresh(lsRefresh), .faultN(faultN)
  );

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    act = {outEnable, lsRefresh, faultN};
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Caller sets the trigger inputs; the first edge enters phase A.
  task automatic powerup(input string tag, input bit noisy);
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < REF; i++) begin
        nxt();
        chk(tag, {1'b0, 3'(1 << p), 1'b1});
        if (noisy && !(p == 2 && i == REF - 1)) begin
          {csHigh, vdsOc, shortGnd, overTemp} = 4'hF;
          bstOk = 3'b000;
        end else begin
          {csHigh, vdsOc, shortGnd, overTemp} = 4'h0;
          bstOk = 3'b111;
        end
      end
    end
    nxt();
    chk(tag, RUNV);
  endtask

  task automatic wake(input string tag);
    sleepReq = 0;
    for (int i = 0; i < WAKE; i++) begin
      nxt();
      chk(tag, OFFV);
    end
    powerup(tag, 0);
  endtask

  initial begin
    repeat (3) nxt();
    chk("R1", OFFV);
    rst_n = 1;
    nxt(); chk("R1", OFFV);
    // R2: either supply missing keeps the block off
    vinOk = 1; vregOk = 0;
    repeat (3) begin nxt(); chk("R2", OFFV); end
    vinOk = 0; vregOk = 1;
    repeat (3) begin nxt(); chk("R2", OFFV); end
    vinOk = 1;
    powerup("R3", 0);
    // R5: current trip through both sources
    for (int s = 0; s < 2; s++) begin
      if (s == 0) csHigh = 1; else vdsOc = 1;
      csLow = 0;
      nxt(); chk("R5", FLTV);
      csHigh = 0; vdsOc = 0;
      repeat (3) begin nxt(); chk("R5", FLTV); end
      csLow = 1;
      nxt(); chk("R5", RUNV);
    end
    // R7 with R3: gate-rail loss, then refresh with faults applied and ignored
    vregOk = 0;
    repeat (3) begin nxt(); chk("R7", FLTV); end
    vregOk = 1;
    powerup("R3", 1);
    // R8: each bootstrap rail from run
    for (int b = 0; b < 3; b++) begin
      bstOk = ~(3'b001 << b);
      powerup("R8", 0);
    end
    // R8: bootstrap loss during a current fault
    csHigh = 1; csLow = 0;
    nxt(); chk("R8", FLTV);
    csHigh = 0; bstOk = 3'b011; csLow = 1;
    powerup("R8", 0);
    // R6: latch sources, cleared by sleep and by gate-rail loss
    for (int s = 0; s < 2; s++) begin
      if (s == 0) shortGnd = 1; else overTemp = 1;
      nxt(); chk("R6", FLTV);
      shortGnd = 0; overTemp = 0; csLow = 1;
      repeat (4) begin nxt(); chk("R6", FLTV); end
      if (s == 0) begin
        sleepReq = 1;
        nxt(); chk("R6", OFFV);
        wake("R4");
      end else begin
        vregOk = 0;
        nxt(); chk("R7", FLTV);
        vregOk = 1;
        powerup("R7", 0);
      end
    end
    // R4: sleep ignores other inputs
    sleepReq = 1;
    nxt(); chk("R4", OFFV);
    shortGnd = 1; vregOk = 0; csHigh = 1; bstOk = 3'b000;
    repeat (3) begin nxt(); chk("R4", OFFV); end
    shortGnd = 0; vregOk = 1; csHigh = 0; bstOk = 3'b111;
    nxt(); chk("R4", OFFV);
    wake("R4");
    // R1: main-rail loss clears a latch without a fault flag
    shortGnd = 1;
    nxt(); chk("R6", FLTV);
    shortGnd = 0; vinOk = 0;
    nxt(); chk("R1", OFFV);
    nxt(); chk("R1", OFFV);
    vinOk = 1;
    powerup("R1", 0);
    // R9: run state shows no refresh bits
    repeat (3) begin nxt(); chk("R9", RUNV); end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule